// File: doc/BRIEF.md
# Finite Pulse Train Generator

This block drives one output pin with a burst of rectangular pulses and then stops by itself. Software sets three 32-bit unsigned values: a high duration in nanoseconds, a low duration in nanoseconds and a pulse count. It writes them with a single valid strobe. A start strobe turns the stored values into clock ticks, checks them, and begins the burst. A stop strobe ends the burst early.

One pulse is a complete high phase followed by a complete low phase, so the pulse period is the high time plus the low time. After exactly the programmed number of pulses, the block raises a one-cycle completion pulse and a sticky done bit. A stopped burst does not signal completion. Instead it sets an aborted bit. A setting that cannot be represented in ticks raises an error flag, and no pulse is produced.

Durations are converted with a clock-frequency parameter. The tick count is the nearest whole number of clock periods, and exact halves round up. Each phase counter is `CNT_W` bits wide.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, `pulse_o`, `busy`, `done_pulse`, `done_sticky`, `aborted` and `cfg_err` are all 0.
- R2: A duration of `ns` nanoseconds becomes floor((ns*CLK_HZ + 500000000) / 1000000000) ticks. At the default 125 MHz clock this is floor((ns+4)/8) ticks.
- R3: A start is rejected if either tick count is 0 or greater than 2^CNT_W-1. A rejected start sets `cfg_err` in the next cycle, and neither `busy` nor `pulse_o` rises.
- R4: An accepted start with count N>0 drives `pulse_o` high from the next cycle. The output then repeats N times: high for H tick cycles, then low for L tick cycles. `busy` stays high for the whole burst.
- R5: The cycle after the last low cycle, `busy` falls and `done_pulse` is high for exactly one cycle. `done_sticky` is set at the same time and stays set until the next accepted start clears it.
- R6: A stop while `busy` is high drives `busy` and `pulse_o` low in the next cycle and sets `aborted`. `done_pulse` and `done_sticky` are not set. A stop while idle has no effect.
- R7: A valid start with count 0 raises `done_pulse` and `done_sticky` in the next cycle. `busy` and `pulse_o` stay low.
- R8: The configuration is captured when a start is accepted. Writes made during a burst only apply to the next start, and a start while `busy` is high is ignored.
- R9: `pulse_o` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Valid strobe that stores the three setting values |
| cfg_high_ns | input | 32 | High duration in nanoseconds |
| cfg_low_ns | input | 32 | Low duration in nanoseconds |
| cfg_count | input | 32 | Number of pulses |
| start | input | 1 | Begin a burst (ignored while busy) |
| stop | input | 1 | End a running burst at once |
| pulse_o | output | 1 | Pulse output, low when idle |
| busy | output | 1 | Burst in progress |
| done_pulse | output | 1 | One-cycle completion event |
| done_sticky | output | 1 | Completion status, cleared by next accepted start |
| aborted | output | 1 | Last burst was stopped early |
| cfg_err | output | 1 | Last start was rejected |

## Verification
The burst is driven with several timing shapes:
- equal one-tick phases, which catch off-by-one errors in the phase reload;
- unequal phases, which would expose swapped high and low counts;
- durations that land on exact half-tick points, which separate round-half-up from truncation;
- the largest tick count that still fits the counter next to the smallest that does not, which checks the range limit.

Further runs cover a zero count, stops both mid-burst and while idle, and configuration writes plus a second start during a burst. Every cycle, all six outputs are compared with a queue-based model of the expected waveform. That comparison shows a wrong pulse count apart from a wrong phase length, a missing abort and a late completion.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } pt_state_e;

  localparam int unsigned CFG_W   = 32;
  localparam int unsigned NUM_DUR = 2;  // index 0: high, 1: low

endpackage

// File: rtl/pulse_cfg_regs.sv
module pulse_cfg_regs
  import pulse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] high_ns_i,
  input  logic [CFG_W-1:0] low_ns_i,
  input  logic [CFG_W-1:0] count_i,
  output logic [CFG_W-1:0] high_ns_o,
  output logic [CFG_W-1:0] low_ns_o,
  output logic [CFG_W-1:0] count_o
);

  logic [CFG_W-1:0] high_q, low_q, count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q  <= '0;
      low_q   <= '0;
      count_q <= '0;
    end else if (wr_en) begin
      high_q  <= high_ns_i;
      low_q   <= low_ns_i;
      count_q <= count_i;
    end
  end

  assign high_ns_o = high_q;
  assign low_ns_o  = low_q;
  assign count_o   = count_q;

endmodule

// File: rtl/pulse_tick_conv.sv
module pulse_tick_conv
  import pulse_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [CFG_W-1:0] ns_i,
  output logic [CNT_W-1:0] ticks_o,
  output logic             ok_o
);

  localparam logic [63:0] NS_PER_S  = 64'd1_000_000_000;
  localparam logic [63:0] HALF_S    = 64'd500_000_000;
  localparam logic [63:0] HZ64      = 64'(CLK_HZ);
  localparam logic [63:0] MAX_TICKS = (64'd1 << CNT_W) - 64'd1;

  logic [63:0] scaled;
  logic [63:0] rounded;

  always_comb begin
    scaled  = {32'd0, ns_i} * HZ64 + HALF_S;
    rounded = scaled / NS_PER_S;
    ok_o    = (rounded != 64'd0) && (rounded <= MAX_TICKS);
    ticks_o = rounded[CNT_W-1:0];
  end

endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import pulse_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic             cfg_ok,
  input  logic [CFG_W-1:0] count,
  output logic             pulse_o,
  output logic             busy,
  output logic             done_pulse,
  output logic             done_sticky,
  output logic             aborted,
  output logic             cfg_err
);

  pt_state_e        st_q, st_d;
  logic [CNT_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic [CFG_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;
  logic             sticky_q, sticky_d;
  logic             abort_q, abort_d;
  logic             err_q, err_d;
  logic             accept;
  logic             load_en;

  assign accept  = (st_q == ST_IDLE) && start;
  assign load_en = accept && cfg_ok && (count != '0);

  always_comb begin
    st_d     = st_q;
    phase_d  = phase_q;
    rem_d    = rem_q;
    done_d   = 1'b0;
    sticky_d = sticky_q;
    abort_d  = abort_q;
    err_d    = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          sticky_d = 1'b0;
          abort_d  = 1'b0;
          err_d    = 1'b0;
          if (!cfg_ok) begin
            err_d = 1'b1;
          end else if (count == '0) begin
            done_d   = 1'b1;
            sticky_d = 1'b1;
          end else begin
            st_d    = ST_HIGH;
            rem_d   = count;
            phase_d = high_ticks - 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (stop) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (phase_q == '0) begin
          st_d    = ST_LOW;
          phase_d = lo_q - 1'b1;
        end else begin
          phase_d = phase_q - 1'b1;
        end
      end
      ST_LOW: begin
        if (stop) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (phase_q == '0) begin
          if (rem_q == CFG_W'(1)) begin
            st_d     = ST_IDLE;
            done_d   = 1'b1;
            sticky_d = 1'b1;
          end else begin
            st_d    = ST_HIGH;
            rem_d   = rem_q - 1'b1;
            phase_d = hi_q - 1'b1;
          end
        end else begin
          phase_d = phase_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      phase_q  <= '0;
      rem_q    <= '0;
      done_q   <= 1'b0;
      sticky_q <= 1'b0;
      abort_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      phase_q  <= phase_d;
      rem_q    <= rem_d;
      done_q   <= done_d;
      sticky_q <= sticky_d;
      abort_q  <= abort_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_en) begin
      hi_q <= high_ticks;
      lo_q <= low_ticks;
    end
  end

  assign pulse_o     = (st_q == ST_HIGH);
  assign busy        = (st_q != ST_IDLE);
  assign done_pulse  = done_q;
  assign done_sticky = sticky_q;
  assign aborted     = abort_q;
  assign cfg_err     = err_q;

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (!busy && !pulse_o)); // R6
  AST_STOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (aborted && !done_pulse && !done_sticky)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!busy && done_sticky)); // R5
  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (!busy && !pulse_o)); // R3
  AST_REM_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || (rem_q <= $past(rem_q)))); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !stop) |=> (!cfg_err || $past(cfg_err))); // R8

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import pulse_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned CNT_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_high_ns,
  input  logic [31:0] cfg_low_ns,
  input  logic [31:0] cfg_count,
  input  logic        start,
  input  logic        stop,
  output logic        pulse_o,
  output logic        busy,
  output logic        done_pulse,
  output logic        done_sticky,
  output logic        aborted,
  output logic        cfg_err
);

  logic [CFG_W-1:0] high_ns_s, low_ns_s, count_s;
  logic [CFG_W-1:0] dur_ns [NUM_DUR];
  logic [CNT_W-1:0] dur_ticks [NUM_DUR];
  logic [NUM_DUR-1:0] dur_ok;

  pulse_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .high_ns_i (cfg_high_ns),
    .low_ns_i  (cfg_low_ns),
    .count_i   (cfg_count),
    .high_ns_o (high_ns_s),
    .low_ns_o  (low_ns_s),
    .count_o   (count_s)
  );

  assign dur_ns[0] = high_ns_s;
  assign dur_ns[1] = low_ns_s;

  for (genvar g = 0; g < NUM_DUR; g++) begin : g_conv
    pulse_tick_conv #(
      .CLK_HZ (CLK_HZ),
      .CNT_W  (CNT_W)
    ) u_conv (
      .ns_i    (dur_ns[g]),
      .ticks_o (dur_ticks[g]),
      .ok_o    (dur_ok[g])
    );
  end

  pulse_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop        (stop),
    .high_ticks  (dur_ticks[0]),
    .low_ticks   (dur_ticks[1]),
    .cfg_ok      (&dur_ok),
    .count       (count_s),
    .pulse_o     (pulse_o),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .done_sticky (done_sticky),
    .aborted     (aborted),
    .cfg_err     (cfg_err)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_o); // R9

endmodule

// File: tb/pulse_train_gen_tb.sv
module pulse_train_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_high_ns = '0;
  logic [31:0] cfg_low_ns = '0;
  logic [31:0] cfg_count = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        pulse_o, busy, done_pulse, done_sticky, aborted, cfg_err;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pulse_train_gen dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr),
    .cfg_high_ns (cfg_high_ns), .cfg_low_ns (cfg_low_ns), .cfg_count (cfg_count),
    .start (start), .stop (stop), .pulse_o (pulse_o), .busy (busy),
    .done_pulse (done_pulse), .done_sticky (done_sticky),
    .aborted (aborted), .cfg_err (cfg_err)
  );

  // reference model: a queue of expected output levels
  bit          wave_q[$];
  bit          m_done, m_sticky, m_abort, m_err;
  longint      sh_h, sh_l, sh_n;

  function automatic longint tick_of(longint ns);
    return (ns + 4) / 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q.delete();
      m_done = 0; m_sticky = 0; m_abort = 0; m_err = 0;
      sh_h = 0; sh_l = 0; sh_n = 0;
    end else begin
      m_done = 0;
      if (wave_q.size() > 0) begin
        if (stop) begin
          wave_q.delete();
          m_abort = 1;
        end else begin
          void'(wave_q.pop_front());
          if (wave_q.size() == 0) begin
            m_done = 1; m_sticky = 1;
          end
        end
      end else if (start) begin
        longint ht, lt;
        ht = tick_of(sh_h);
        lt = tick_of(sh_l);
        m_sticky = 0; m_abort = 0; m_err = 0;
        if (ht == 0 || lt == 0 || ht > 65535 || lt > 65535) m_err = 1;
        else if (sh_n == 0) begin
          m_done = 1; m_sticky = 1;
        end else begin
          for (longint p = 0; p < sh_n; p++) begin
            for (longint i = 0; i < ht; i++) wave_q.push_back(1'b1);
            for (longint i = 0; i < lt; i++) wave_q.push_back(1'b0);
          end
        end
      end
      if (cfg_wr) begin
        sh_h = cfg_high_ns; sh_l = cfg_low_ns; sh_n = cfg_count;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  int rises = 0;
  int hi_cycles = 0;
  bit prev_pulse = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ep;
      ep = (wave_q.size() > 0) ? wave_q[0] : 1'b0;
      chk("R4", "pulse_o", pulse_o, ep);
      chk("R4", "busy", busy, wave_q.size() > 0);
      chk("R5", "done_pulse", done_pulse, m_done);
      chk("R5", "done_sticky", done_sticky, m_sticky);
      chk("R6", "aborted", aborted, m_abort);
      chk("R3", "cfg_err", cfg_err, m_err);
      if (pulse_o && !prev_pulse) rises++;
      if (pulse_o) hi_cycles++;
      prev_pulse = pulse_o;
    end
  end

  task automatic wr_cfg(input int unsigned h, input int unsigned l, input int unsigned n);
    @(negedge clk);
    cfg_wr = 1; cfg_high_ns = h; cfg_low_ns = l; cfg_count = n;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 100000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
  endtask

  task automatic finish_tb();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    finish_tb();
  end

  initial begin
    int r0, h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "outputs after reset", {pulse_o, busy, done_pulse, done_sticky, aborted, cfg_err}, 0);

    // R3: start before any config -> zero ticks
    go(); @(negedge clk);
    chk("R3", "err on zero config", cfg_err, 1);
    chk("R9", "pulse low when idle", pulse_o, 0);

    // R4: 2 high ticks, 3 low ticks, 3 pulses
    wr_cfg(16, 24, 3);
    r0 = rises; h0 = hi_cycles;
    go(); wait_idle();
    chk("R4", "pulse count", rises - r0, 3);
    chk("R4", "high cycles", hi_cycles - h0, 6);
    chk("R5", "sticky after burst", done_sticky, 1);

    // R2: rounding half up: 12ns -> 2, 20ns -> 3; and 4ns -> 1, 11ns -> 1
    wr_cfg(12, 20, 2);
    r0 = rises; h0 = hi_cycles;
    go(); wait_idle();
    chk("R2", "rounded high cycles", hi_cycles - h0, 4);
    wr_cfg(4, 11, 4);
    r0 = rises; h0 = hi_cycles;
    go(); wait_idle();
    chk("R2", "single-tick pulses", rises - r0, 4);
    chk("R2", "single-tick highs", hi_cycles - h0, 4);

    // R3: rounds to zero, over range, zero low
    wr_cfg(3, 16, 1); go(); @(negedge clk);
    chk("R3", "3ns rejected", cfg_err, 1);
    wr_cfg(524284, 16, 1); go(); @(negedge clk);
    chk("R3", "over range rejected", cfg_err, 1);
    wr_cfg(16, 0, 1); go(); @(negedge clk);
    chk("R3", "zero low rejected", {cfg_err, busy}, 2);

    // R3: largest representable tick count accepted
    wr_cfg(524283, 4, 1);
    h0 = hi_cycles;
    go(); wait_idle();
    chk("R3", "max ticks accepted", hi_cycles - h0, 65535);

    // R7: zero count
    wr_cfg(16, 16, 0);
    r0 = rises;
    go();
    chk("R7", "done pulse on zero count", done_pulse, 1);
    @(negedge clk);
    chk("R7", "no pulse on zero count", rises - r0, 0);

    // R6: stop mid-burst; stop while idle
    wr_cfg(40, 40, 10);
    go();
    repeat (12) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    chk("R6", "stopped", {busy, pulse_o, aborted, done_sticky}, 2);
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    chk("R6", "idle stop no effect", {busy, aborted}, 1);

    // R8: writes and start during burst
    wr_cfg(8, 8, 5);
    r0 = rises;
    go();
    wr_cfg(80, 80, 1);
    go();
    wait_idle();
    chk("R8", "burst kept latched count", rises - r0, 5);
    r0 = rises; h0 = hi_cycles;
    go(); wait_idle();
    chk("R8", "next start uses new cfg", hi_cycles - h0, 10);

    // R5: back-to-back start right after done
    wr_cfg(8, 16, 2);
    go(); wait_idle(); go(); wait_idle();
    chk("R5", "sticky after second burst", done_sticky, 1);

    repeat (3) @(negedge clk);
    finish_tb();
  end

endmodule